// File: doc/BRIEF.md
# Prioritized Interrupt Autovector Generator

This block gathers fourteen interrupt request lines from the endpoint FIFO flags and the waveform engine. It drives one shared interrupt line toward a small 8-bit CPU core. Each source has its own sticky pending bit, which a rising request edge sets and a write-one-to-clear strobe clears. Each source also has an enable mask bit. The shared line is high while any pending source is also enabled.

Each enabled pending source maps to a vector byte. The lowest source index has the highest priority. When the CPU acknowledges the interrupt, the block latches the vector byte of the winning source. The CPU then jumps to a fixed entry point, where a jump instruction reads its two operand bytes from the code locations 0x0054 and 0x0055. If autovectoring is enabled, the block replaces the byte fetched at 0x0055 with the latched vector. It does not touch the page byte at 0x0054. The jump therefore lands on the entry in the jump table that belongs to the winning source. The block does not contain the CPU or the code memory.

Top module: `irq_autovec_top`

## Requirements
- R1: After reset no source is pending, `irq_o` is 0, and the latched vector is 0x80.
- R2: A 0-to-1 change on `req_i[i]`, seen between two rising clock edges, sets pending bit i. A request held high sets the bit again only after it has gone low and risen once more.
- R3: A 1 on `clr_i[i]` at a clock edge clears pending bit i. If a new rising edge of the same source arrives in that same cycle, the bit stays set.
- R4: `irq_o` is 1 exactly when at least one source i has both its pending bit set and `mask_en_i[i]` = 1.
- R5: Among the enabled pending sources, the lowest index wins. Source index map: 0–3 are the programmable flags of endpoints 2, 4, 6 and 8; 4–7 are the empty flags of those endpoints; 8–11 are their full flags; 12 is waveform-operation-complete; 13 is waveform-event.
- R6: The vector byte of source i is 0x80 + 4·i, which gives 0x80 through 0xB4. `live_vec_o` always shows the vector of the current winner.
- R7: When `irq_ack_i` is 1 at a clock edge, the vector of the current winner is latched. It stays unchanged until the next acknowledge, even if a higher-priority request arrives in between.
- R8: When `autovec_en_i` = 1 and `fetch_addr_i` = 0x0055, `fetch_data_o` is the latched vector. When `autovec_en_i` = 0, the code byte passes through unchanged at 0x0055 as well.
- R9: For every fetch address other than 0x0055, including 0x0053 and 0x0054, `fetch_data_o` equals `code_data_i`.
- R10: An acknowledge taken while no enabled source is pending latches 0x80.
- R11: A source with its mask bit at 0 does not affect `irq_o`, `live_vec_o` or the latched vector, even while its pending bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 14 | Raw request lines, index = priority order |
| mask_en_i | input | 14 | Per-source enable mask |
| clr_i | input | 14 | Write-one-to-clear strobes for the pending bits |
| autovec_en_i | input | 1 | Enables substitution of the vector byte |
| irq_ack_i | input | 1 | CPU acknowledge; latches the vector |
| fetch_addr_i | input | 16 | Code fetch address |
| code_data_i | input | 8 | Byte returned by code memory |
| fetch_data_o | output | 8 | Byte delivered to the CPU |
| irq_o | output | 1 | Shared interrupt request |
| live_vec_o | output | 8 | Vector of the current winner (0x80 when none) |

## Verification
The bench goes after priority when several sources are pending at once. A reversed or broken priority chain would send the jump to the wrong table entry. It checks the vector of every source one by one, so an error in the step or base value shows up as an off-by-four byte. It raises a higher-priority request between acknowledge and fetch: a design that does not latch at acknowledge would swap the operand byte in the middle of the jump. It also sweeps the addresses around the patch location and turns autovectoring off. A loose address compare would corrupt the page byte at 0x0054 or the entry instruction. It also covers a request held high across a clear, a clear colliding with a new edge, masked pending sources, and an acknowledge with nothing pending. A design that handles any of these wrongly would show a spurious re-interrupt, a lost event, or a vector taken from a masked or stale source.

// File: rtl/irq_av_pkg.sv
// Package: shared constants and the vector function of the autovector block.
// Assumes vectors fit in one byte for every source index in use.
package irq_av_pkg;
    localparam int NUM_SRC_DEF  = 14;
    localparam int VEC_BASE_DEF = 'h80;
    localparam int VEC_STEP_DEF = 4;

    // Vector byte of a source index.
    function automatic logic [7:0] vec_of(input int idx, input int base, input int step);
        return 8'(base + step * idx);
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
// Module: sticky pending bits, one per source.
// A rising request edge sets the bit; a clear strobe resets it; a new edge wins
// over a clear in the same cycle so that no event is lost.
// Assumes req_i is synchronous to clk.
module irq_pend_bank #(
    parameter int NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] rise;

    // Edge detect against the previous sample of the request lines.
    always_comb rise = req_i & ~req_q;

    // Keep the previous request sample.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
            // Per-source sticky flag: set on edge, clear on strobe, set wins.
            always_ff @(posedge clk) begin
                if (!rst_n)        pend_q[g] <= 1'b0;
                else if (rise[g])  pend_q[g] <= 1'b1;
                else if (clr_i[g]) pend_q[g] <= 1'b0;
            end

            a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (req_i[g] && !req_q[g]) |=> pend_q[g]);
            a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[g] && !(req_i[g] && !req_q[g])) |=> !pend_q[g]);
        end
    endgenerate

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
// Module: fixed-priority encoder, lowest index wins.
// Builds a blocking chain across the sources and encodes the one-hot grant.
// Assumes IDX_W is wide enough for NUM_SRC-1.
module irq_prio_enc #(
    parameter int NUM_SRC = 14,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] active_i,
    output logic [NUM_SRC-1:0] grant_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               any_o
);
    logic [NUM_SRC:0] blocked;

    assign blocked[0] = 1'b0;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
            assign grant_o[g]   = active_i[g] & ~blocked[g];
            assign blocked[g+1] = blocked[g] | active_i[g];
        end
    endgenerate

    // Convert the one-hot grant into an index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    assign any_o = blocked[NUM_SRC];
endmodule

// File: rtl/irq_vec_unit.sv
// Module: computes the live vector byte and latches it on acknowledge.
// With no winner the live vector is the base value.
module irq_vec_unit #(
    parameter int NUM_SRC  = 14,
    parameter int IDX_W    = $clog2(NUM_SRC),
    parameter int VEC_BASE = 'h80,
    parameter int VEC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             any_i,
    input  logic             ack_i,
    output logic [7:0]       live_vec_o,
    output logic [7:0]       held_vec_o
);
    import irq_av_pkg::*;

    // Map the winning index to its vector byte.
    always_comb begin
        if (any_i) live_vec_o = vec_of(int'(idx_i), VEC_BASE, VEC_STEP);
        else       live_vec_o = 8'(VEC_BASE);
    end

    // Capture the vector at the acknowledge edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     held_vec_o <= 8'(VEC_BASE);
        else if (ack_i) held_vec_o <= live_vec_o;
    end

    a_r7_hold_between_acks: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> $stable(held_vec_o));
endmodule

// File: rtl/irq_fetch_patch.sv
// Module: replaces the code byte at one fixed address with the held vector.
// Assumes the fetch path is combinational from address to data.
module irq_fetch_patch #(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] PATCH_ADDR = 16'h0055
) (
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        code_i,
    input  logic [7:0]        vec_i,
    output logic [7:0]        data_o
);
    localparam logic [ADDR_W-1:0] HIT = ADDR_W'(PATCH_ADDR);

    // Select between memory byte and vector.
    always_comb begin
        if (en_i && (addr_i == HIT)) data_o = vec_i;
        else                         data_o = code_i;
    end
endmodule

// File: rtl/irq_autovec_top.sv
// Module: prioritized interrupt autovector generator (top).
// Pending bits feed a masked priority encoder; the vector is latched at
// acknowledge and patched into the code fetch at PATCH_ADDR.
// Assumes all inputs are synchronous to clk.
module irq_autovec_top #(
    parameter int          NUM_SRC    = 14,
    parameter int          ADDR_W     = 16,
    parameter int          VEC_BASE   = 'h80,
    parameter int          VEC_STEP   = 4,
    parameter logic [15:0] PATCH_ADDR = 16'h0055
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] mask_en_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic               autovec_en_i,
    input  logic               irq_ack_i,
    input  logic [ADDR_W-1:0]  fetch_addr_i,
    input  logic [7:0]         code_data_i,
    output logic [7:0]         fetch_data_o,
    output logic               irq_o,
    output logic [7:0]         live_vec_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] grant;
    logic [IDX_W-1:0]   win_idx;
    logic               win_any;
    logic [7:0]         held_vec;

    irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_i), .pend_o(pend)
    );

    // Only enabled pending sources compete.
    always_comb active = pend & mask_en_i;

    irq_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enc (
        .active_i(active), .grant_o(grant), .idx_o(win_idx), .any_o(win_any)
    );

    irq_vec_unit #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W),
                   .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_vec (
        .clk(clk), .rst_n(rst_n), .idx_i(win_idx), .any_i(win_any),
        .ack_i(irq_ack_i), .live_vec_o(live_vec_o), .held_vec_o(held_vec)
    );

    irq_fetch_patch #(.ADDR_W(ADDR_W), .PATCH_ADDR(PATCH_ADDR)) u_patch (
        .en_i(autovec_en_i), .addr_i(fetch_addr_i), .code_i(code_data_i),
        .vec_i(held_vec), .data_o(fetch_data_o)
    );

    assign irq_o = win_any;

    a_r5_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r4_irq_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (grant != '0));
    a_r11_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~mask_en_i) == '0);
    a_r10_empty_ack_base: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && !irq_o) |=> held_vec == 8'(VEC_BASE));
    a_r9_other_addr_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr_i != ADDR_W'(PATCH_ADDR)) |-> fetch_data_o == code_data_i);
endmodule

// File: tb/test_irq_autovec_top.sv
module test_irq_autovec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] req = '0, mask = '1, clr = '0;
    logic        av = 1'b1, ack = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  code;
    logic [7:0]  fdata, lvec;
    logic        irq;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // Reference model state.
    bit  mp [14];
    bit  mreq [14];
    int  mvec = 'h80;

    always #10 clk = ~clk;
    always_comb code = addr[7:0] ^ 8'hA5;

    irq_autovec_top i_irq_autovec_top (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_en_i(mask), .clr_i(clr),
        .autovec_en_i(av), .irq_ack_i(ack), .fetch_addr_i(addr),
        .code_data_i(code), .fetch_data_o(fdata), .irq_o(irq), .live_vec_o(lvec)
    );

    function automatic int exp_live();
        int v = 'h80;
        for (int i = 13; i >= 0; i--) if (mp[i] && mask[i]) v = 'h80 + 4 * i;
        return v;
    endfunction

    function automatic bit exp_irq();
        bit r = 0;
        foreach (mp[i]) r |= mp[i] & mask[i];
        return r;
    endfunction

    // Behavioural model updated at each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mp[i]) begin mp[i] = 0; mreq[i] = 0; end
            mvec = 'h80;
        end else begin
            if (ack) mvec = exp_live();
            foreach (mp[i]) begin
                if (req[i] && !mreq[i]) mp[i] = 1;
                else if (clr[i])        mp[i] = 0;
                mreq[i] = req[i];
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq, exp_irq(), "R4 irq");
            chk(lvec, exp_live(), "R6 live vector");
            chk(fdata, (av && addr == 16'h0055) ? mvec : code, "R8/R9 fetch");
        end
    end

    task automatic tick(); @(posedge clk); #2; endtask

    task automatic pulse_req(input logic [13:0] m);
        req = m; tick(); req = '0; tick();
    endtask

    task automatic do_ack(); ack = 1; tick(); ack = 0; endtask

    task automatic clear(input logic [13:0] m); clr = m; tick(); clr = '0; endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1; #1;
        chk(irq, 0, "R1 irq after reset");
        addr = 16'h0055; #1;
        chk(fdata, 'h80, "R1 held vector after reset");

        // R6: every source alone.
        for (int i = 0; i < 14; i++) begin
            pulse_req(14'(1) << i);
            chk(irq, 1, "R2 edge sets pending");
            do_ack(); #1;
            chk(fdata, 'h80 + 4 * i, "R6 vector per source");
            clear(14'(1) << i); #1;
            chk(irq, 0, "R3 clear strobe");
        end

        // R5: several pending at once.
        pulse_req(14'b10_0010_0010_0000);
        do_ack(); #1; chk(fdata, 'h94, "R5 lowest index wins");
        clear(14'(1) << 5); do_ack(); #1; chk(fdata, 'hA4, "R5 next winner");
        clear(14'(1) << 9); do_ack(); #1; chk(fdata, 'hB4, "R5 last winner");
        clear(14'(1) << 13);

        // R7: higher request after ack does not change held byte.
        pulse_req(14'(1) << 10); do_ack();
        pulse_req(14'(1) << 1); #1;
        chk(lvec, 'h84, "R7 live follows new winner");
        chk(fdata, 'hA8, "R7 held vector stable");
        clear('1);

        // R11: masked sources ignored.
        mask[0] = 0; mask[2] = 0;
        pulse_req(14'(1) << 0); #1;
        chk(irq, 0, "R11 masked irq");
        chk(lvec, 'h80, "R11 masked live vector");
        pulse_req(14'b00_0000_1000_0100);
        do_ack(); #1; chk(fdata, 'h9C, "R11 masked not latched");
        mask = '1; #1;
        chk(lvec, 'h80, "R4 unmask restores winner");
        clear('1);

        // R8: autovector disabled.
        pulse_req(14'(1) << 4); do_ack();
        av = 0; #1; chk(fdata, 8'h55 ^ 8'hA5, "R8 disabled passes code");
        av = 1; #1; chk(fdata, 'h90, "R8 enabled substitutes");

        // R9: address sweep.
        for (int a = 'h50; a <= 'h5A; a++) begin
            addr = 16'(a); #1;
            chk(fdata, (a == 'h55) ? 'h90 : (a ^ 'hA5), "R9 address sweep");
        end
        addr = 16'h1055; #1;
        chk(fdata, 8'h55 ^ 8'hA5, "R9 upper address bits");
        addr = 16'h0055;
        clear('1);

        // R10: ack with nothing pending.
        do_ack(); #1; chk(fdata, 'h80, "R10 empty ack");

        // R2: held level does not re-set after clear.
        req[3] = 1; tick(); clear(14'(1) << 3); tick(); #1;
        chk(irq, 0, "R2 held level no re-set");
        // R3: clear colliding with new edge.
        req[3] = 0; tick();
        req[3] = 1; clr[3] = 1; tick(); clr = '0; #1;
        chk(irq, 1, "R3 edge wins over clear");
        req = '0; clear('1); tick();

        finish_up();
    end
endmodule